// File: doc/BRIEF.md
# Low-Power Exit Phase Sequencer

This block times the wake-up of a memory device leaving either of its two low-power states: a light nap or a deep power-down. Three small timing registers, loaded through a plain write/read port at fixed control addresses, hold the phase end points. When an exit request arrives, the sequencer counts serial-clock cycles. It raises a phase-A flag, then a phase-B flag, and gives a one-cycle done pulse once the programmed total has elapsed.

Nap end points are counted in single clocks. The power-down end points use coarse units: the phase-A field counts in 64-clock steps and the combined field counts in 256-clock steps. Only the low bits of each field exist. A count of zero is illegal. It is reported on an error output and then treated as one, so an exit never completes instantly. A separate flag carries the device-select offset setting: 1 means a 1.5-cycle offset and 0 means a 0.5-cycle offset. The end points are captured when a request is accepted, so register writes made during an exit do not change that exit.

Top module: `lp_exit_seq`

## Requirements
- R1: After reset, address 0x45 reads 0x0421, addresses 0x46 and 0x47 each read 0x0001, `dqs_late` is 1, and `busy`, `phase_a`, `phase_b`, `exit_done` and `zero_err` are 0.
- R2: Address 0x45 holds the nap fields: bits 4:0 are the phase-A count, bits 9:5 are the combined count, and bit 10 is the select-offset bit. Bits 15:11 read as zero, and writes to them are ignored.
- R3: Address 0x46 holds a 6-bit power-down phase-A count in bits 5:0. Address 0x47 holds a 3-bit power-down combined count in bits 2:0. Higher bits read as zero, and writes to them are ignored. Any other address reads zero and stores nothing.
- R4: A nap request accepted while idle raises `phase_a` in the first cycle after the accepting edge, for exactly phase-A-count cycles. `phase_b` then stays high until the combined count of cycles since the start has elapsed.
- R5: `exit_done` is a single-cycle pulse in the cycle after the last phase cycle. `busy` is high from the first exit cycle through the done cycle and is low in the cycle after.
- R6: A power-down request uses a phase-A end point of field×64 cycles and a total of field×256 cycles.
- R7: If the combined end point is at or before the phase-A end point, no `phase_b` cycle occurs and done follows phase A directly.
- R8: A write to 0x45, 0x46 or 0x47 that leaves any count field it carries at zero pulses `zero_err` in the cycle after the write. The zero is stored and read back, but the sequencer uses 1 in its place.
- R9: Requests that arrive while `busy` is high are ignored and do not change the running exit.
- R10: `dqs_late` equals bit 10 of register 0x45.
- R11: When nap and power-down requests arrive in the same idle cycle, the nap exit runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (write and read) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| nap_exit_req | input | 1 | Request to leave nap |
| pdn_exit_req | input | 1 | Request to leave power-down |
| phase_a | output | 1 | First exit phase in progress |
| phase_b | output | 1 | Second exit phase in progress |
| exit_done | output | 1 | One-cycle pulse when the exit completes |
| busy | output | 1 | Exit sequence active |
| zero_err | output | 1 | A zero count field was written (one-cycle pulse) |
| dqs_late | output | 1 | Select offset: 1 = 1.5 cycles, 0 = 0.5 cycles |

## Verification
Read data is combinational, so it is checked in the same cycle the address is applied. `zero_err` is registered at the write edge and is sampled at the following falling edge. `phase_a` starts in the first cycle after the request edge. The bench drives the request for one cycle, then counts `phase_a` cycles and then `phase_b` cycles at each falling edge. It expects `exit_done` in the first sampled cycle after phase B and `busy` low in the sample after that. Because phase lengths are measured as counts rather than fixed delays, an off-by-one at either phase boundary appears as a count mismatch.

// File: rtl/lp_exit_pkg.sv
package lp_exit_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PH_A = 2'd1,
        SEQ_PH_B = 2'd2,
        SEQ_DONE = 2'd3
    } seq_st_e;
endpackage

// File: rtl/lp_exit_regs.sv
module lp_exit_regs #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int NAP_W    = 5,
    parameter int PDA_W    = 6,
    parameter int PDX_W    = 3,
    parameter int NAP_ADDR = 'h45,
    parameter int PDA_ADDR = 'h46,
    parameter int PDX_ADDR = 'h47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NAP_W-1:0]  napa_eff,
    output logic [NAP_W-1:0]  napx_eff,
    output logic [PDA_W-1:0]  pda_eff,
    output logic [PDX_W-1:0]  pdx_eff,
    output logic              dqs,
    output logic              zero_err
);
    localparam int NX_LO   = NAP_W;
    localparam int DQS_BIT = 2 * NAP_W;
    localparam logic [ADDR_W-1:0] A_NAP = ADDR_W'(NAP_ADDR);
    localparam logic [ADDR_W-1:0] A_PDA = ADDR_W'(PDA_ADDR);
    localparam logic [ADDR_W-1:0] A_PDX = ADDR_W'(PDX_ADDR);

    typedef struct packed {
        logic [NAP_W-1:0] napa;
        logic [NAP_W-1:0] napx;
        logic             dqs;
        logic [PDA_W-1:0] pda;
        logic [PDX_W-1:0] pdx;
        logic             err;
    } regs_t;

    regs_t q, d;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:DQS_BIT+1];

    always_comb begin
        d     = q;
        d.err = 1'b0;
        if (wr) begin
            if (addr == A_NAP) begin
                d.napa = wdata[NAP_W-1:0];
                d.napx = wdata[NX_LO +: NAP_W];
                d.dqs  = wdata[DQS_BIT];
                d.err  = (wdata[NAP_W-1:0] == '0) || (wdata[NX_LO +: NAP_W] == '0);
            end else if (addr == A_PDA) begin
                d.pda = wdata[PDA_W-1:0];
                d.err = (wdata[PDA_W-1:0] == '0);
            end else if (addr == A_PDX) begin
                d.pdx = wdata[PDX_W-1:0];
                d.err = (wdata[PDX_W-1:0] == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.napa <= NAP_W'(1);
            q.napx <= NAP_W'(1);
            q.dqs  <= 1'b1;
            q.pda  <= PDA_W'(1);
            q.pdx  <= PDX_W'(1);
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_NAP) begin
            rdata[NAP_W-1:0]      = q.napa;
            rdata[NX_LO +: NAP_W] = q.napx;
            rdata[DQS_BIT]        = q.dqs;
        end else if (addr == A_PDA) begin
            rdata[PDA_W-1:0] = q.pda;
        end else if (addr == A_PDX) begin
            rdata[PDX_W-1:0] = q.pdx;
        end
    end

    assign napa_eff = (q.napa == '0) ? NAP_W'(1) : q.napa;
    assign napx_eff = (q.napx == '0) ? NAP_W'(1) : q.napx;
    assign pda_eff  = (q.pda  == '0) ? PDA_W'(1) : q.pda;
    assign pdx_eff  = (q.pdx  == '0) ? PDX_W'(1) : q.pdx;
    assign dqs      = q.dqs;
    assign zero_err = q.err;
endmodule

// File: rtl/lp_exit_ctr.sv
module lp_exit_ctr
    import lp_exit_pkg::*;
#(
    parameter int NAP_W  = 5,
    parameter int PDA_W  = 6,
    parameter int PDX_W  = 3,
    parameter int PDA_SH = 6,
    parameter int PDX_SH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NAP_W-1:0] napa,
    input  logic [NAP_W-1:0] napx,
    input  logic [PDA_W-1:0] pda,
    input  logic [PDX_W-1:0] pdx,
    input  logic             nap_req,
    input  logic             pdn_req,
    output logic             phase_a,
    output logic             phase_b,
    output logic             done,
    output logic             busy
);
    localparam int NAP_MAX = (1 << NAP_W) - 1;
    localparam int PDA_MAX = ((1 << PDA_W) - 1) << PDA_SH;
    localparam int PDX_MAX = ((1 << PDX_W) - 1) << PDX_SH;
    localparam int M1      = (NAP_MAX > PDA_MAX) ? NAP_MAX : PDA_MAX;
    localparam int END_MAX = (M1 > PDX_MAX) ? M1 : PDX_MAX;
    localparam int CNT_W   = $clog2(END_MAX + 2);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] end_a;
        logic [CNT_W-1:0] end_t;
    } seq_t;

    seq_t q, d;

    logic [CNT_W-1:0] nap_a, nap_t, pdn_a, pdn_t;
    assign nap_a = CNT_W'(napa);
    assign nap_t = CNT_W'(napx);
    assign pdn_a = CNT_W'(pda) << PDA_SH;
    assign pdn_t = CNT_W'(pdx) << PDX_SH;

    always_comb begin
        d = q;
        unique case (q.st)
            SEQ_IDLE: begin
                if (nap_req || pdn_req) begin
                    d.st    = SEQ_PH_A;
                    d.cnt   = CNT_W'(1);
                    d.end_a = nap_req ? nap_a : pdn_a;
                    d.end_t = nap_req ? nap_t : pdn_t;
                end
            end
            SEQ_PH_A: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt >= q.end_a)
                    d.st = (q.end_t > q.end_a) ? SEQ_PH_B : SEQ_DONE;
            end
            SEQ_PH_B: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt >= q.end_t)
                    d.st = SEQ_DONE;
            end
            SEQ_DONE: d.st = SEQ_IDLE;
            default:  d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= SEQ_IDLE;
            q.cnt   <= '0;
            q.end_a <= '0;
            q.end_t <= '0;
        end else begin
            q <= d;
        end
    end

    assign phase_a = (q.st == SEQ_PH_A);
    assign phase_b = (q.st == SEQ_PH_B);
    assign done    = (q.st == SEQ_DONE);
    assign busy    = (q.st != SEQ_IDLE);
endmodule

// File: rtl/lp_exit_seq.sv
module lp_exit_seq #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int NAP_W    = 5,
    parameter int PDA_W    = 6,
    parameter int PDX_W    = 3,
    parameter int PDA_SH   = 6,
    parameter int PDX_SH   = 8,
    parameter int NAP_ADDR = 'h45,
    parameter int PDA_ADDR = 'h46,
    parameter int PDX_ADDR = 'h47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              nap_exit_req,
    input  logic              pdn_exit_req,
    output logic              phase_a,
    output logic              phase_b,
    output logic              exit_done,
    output logic              busy,
    output logic              zero_err,
    output logic              dqs_late
);
    logic [NAP_W-1:0] napa_e, napx_e;
    logic [PDA_W-1:0] pda_e;
    logic [PDX_W-1:0] pdx_e;

    lp_exit_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NAP_W(NAP_W), .PDA_W(PDA_W),
        .PDX_W(PDX_W), .NAP_ADDR(NAP_ADDR), .PDA_ADDR(PDA_ADDR), .PDX_ADDR(PDX_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .napa_eff(napa_e), .napx_eff(napx_e), .pda_eff(pda_e),
        .pdx_eff(pdx_e), .dqs(dqs_late), .zero_err(zero_err)
    );

    lp_exit_ctr #(
        .NAP_W(NAP_W), .PDA_W(PDA_W), .PDX_W(PDX_W), .PDA_SH(PDA_SH), .PDX_SH(PDX_SH)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .napa(napa_e), .napx(napx_e), .pda(pda_e),
        .pdx(pdx_e), .nap_req(nap_exit_req), .pdn_req(pdn_exit_req),
        .phase_a(phase_a), .phase_b(phase_b), .done(exit_done), .busy(busy)
    );
endmodule

// File: rtl/lp_exit_chk.sv
module lp_exit_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int PDA_W    = 6,
    parameter int PDX_W    = 3,
    parameter int PDA_ADDR = 'h46,
    parameter int PDX_ADDR = 'h47
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              nap_exit_req,
    input logic              pdn_exit_req,
    input logic              phase_a,
    input logic              phase_b,
    input logic              exit_done,
    input logic              busy,
    input logic              zero_err
);
    a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (nap_exit_req || pdn_exit_req) && !busy |=> phase_a && busy);

    a_r5_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phase_a, phase_b, exit_done}));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exit_done |=> !exit_done && !busy);

    a_r4_b_follows: assert property (@(posedge clk) disable iff (!rst_n)
        phase_b |=> phase_b || exit_done);

    a_r7_a_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_a) |-> phase_b || exit_done);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !exit_done |=> busy);

    a_r3_pdx_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == ADDR_W'(PDX_ADDR) |-> reg_rdata[DATA_W-1:PDX_W] == '0);

    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == ADDR_W'(PDA_ADDR) && reg_wdata[PDA_W-1:0] == '0 |=> zero_err);
endmodule

bind lp_exit_seq lp_exit_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PDA_W(PDA_W), .PDX_W(PDX_W),
    .PDA_ADDR(PDA_ADDR), .PDX_ADDR(PDX_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nap_exit_req(nap_exit_req),
    .pdn_exit_req(pdn_exit_req), .phase_a(phase_a), .phase_b(phase_b),
    .exit_done(exit_done), .busy(busy), .zero_err(zero_err)
);

// File: tb/lp_exit_seq_test.sv
module lp_exit_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic        nap_exit_req = 1'b0;
    logic        pdn_exit_req = 1'b0;
    logic        phase_a, phase_b, exit_done, busy, zero_err, dqs_late;

    int n_vec = 0;
    int n_bad = 0;

    // {addr, write data, expected read-back, expected zero_err}
    localparam logic [40:0] VECS [0:NV-1] = '{
        {8'h45, 16'hFFFF, 16'h07FF, 1'b0},
        {8'h45, 16'h0421, 16'h0421, 1'b0},
        {8'h45, 16'h0000, 16'h0000, 1'b1},
        {8'h46, 16'hFFFF, 16'h003F, 1'b0},
        {8'h46, 16'hFFC0, 16'h0000, 1'b1},
        {8'h47, 16'hFFFF, 16'h0007, 1'b0},
        {8'h47, 16'hFFF8, 16'h0000, 1'b1},
        {8'h44, 16'hFFFF, 16'h0000, 1'b0},
        {8'h45, 16'h0003, 16'h0003, 1'b1}
    };

    lp_exit_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nap_exit_req(nap_exit_req),
        .pdn_exit_req(pdn_exit_req), .phase_a(phase_a), .phase_b(phase_b),
        .exit_done(exit_done), .busy(busy), .zero_err(zero_err), .dqs_late(dqs_late)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] dat);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = dat;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic run_exit(input bit nap, input bit pdn, input bit hold_pdn,
                            input int exp_a, input int exp_b, input string tag);
        int na = 0;
        int nb = 0;
        int guard = 0;
        @(negedge clk);
        nap_exit_req = nap; pdn_exit_req = pdn;
        @(negedge clk);
        nap_exit_req = 1'b0; pdn_exit_req = hold_pdn;
        while (phase_a === 1'b1 && guard < 6000) begin
            na++; guard++;
            @(negedge clk);
        end
        while (phase_b === 1'b1 && guard < 6000) begin
            nb++; guard++;
            @(negedge clk);
        end
        pdn_exit_req = 1'b0;
        chk({tag, " phase A cycles"}, na, exp_a);
        chk({tag, " phase B cycles"}, nb, exp_b);
        chk({tag, " R5 done pulse"}, int'(exit_done), 1);
        chk({tag, " R5 busy in done cycle"}, int'(busy), 1);
        @(negedge clk);
        chk({tag, " R5 done ends"}, int'(exit_done), 0);
        chk({tag, " R5 busy ends"}, int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(8'h45, 'h0421, "R1 nap reg reset");
        rd_chk(8'h46, 'h0001, "R1 pdn A reg reset");
        rd_chk(8'h47, 'h0001, "R1 pdn total reg reset");
        chk("R1 dqs_late reset", int'(dqs_late), 1);
        chk("R1 busy reset", int'(busy), 0);
        chk("R1 zero_err reset", int'(zero_err), 0);

        // R2 R3 R8: register map walk
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i][40:33], VECS[i][32:17]);
            chk("R8 zero_err after write", int'(zero_err), int'(VECS[i][0]));
            #1;
            chk("R2/R3 read-back", int'(reg_rdata), int'(VECS[i][16:1]));
        end

        // R8: zero fields act as 1 (nap A=3, total 0->1; pdn A 0->64, total 0->256)
        run_exit(1'b1, 1'b0, 1'b0, 3, 0, "R8 nap with zero total");
        run_exit(1'b0, 1'b1, 1'b0, 64, 192, "R8 pdn with zero fields");

        // R10 R4: A=3 total=8, select offset 0
        wr(8'h45, 16'h0103);
        chk("R10 dqs_late low", int'(dqs_late), 0);
        run_exit(1'b1, 1'b0, 1'b0, 3, 5, "R4 nap 3/8");

        // R7: A=6 total=4, select offset 1
        wr(8'h45, 16'h0486);
        chk("R10 dqs_late high", int'(dqs_late), 1);
        run_exit(1'b1, 1'b0, 1'b0, 6, 0, "R7 nap skip B");

        // R6: pdn A=2*64 total=1*256
        wr(8'h46, 16'h0002);
        wr(8'h47, 16'h0001);
        run_exit(1'b0, 1'b1, 1'b0, 128, 128, "R6 pdn 128/256");
        wr(8'h46, 16'h0005);
        run_exit(1'b0, 1'b1, 1'b0, 320, 0, "R7 pdn skip B");

        // R9: pdn request held during a nap exit
        wr(8'h45, 16'h0103);
        run_exit(1'b1, 1'b0, 1'b1, 3, 5, "R9 request while busy");

        // R11: simultaneous requests -> nap
        run_exit(1'b1, 1'b1, 1'b0, 3, 5, "R11 nap priority");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule